// File: doc/BRIEF.md
# Host Port Cycle Decoder

This block is the host-facing front end of a parallel host port. An external host, already brought into the local clock domain, drives a chip select, two data strobes, a two-bit cycle code, a read/write line, a halfword-select line and a 16-bit data bus. The block forms one internal strobe from these inputs. When that strobe becomes active it latches the cycle code and decodes it into one of three targets: a small control register, a pair of 32-bit address registers, or a data cycle.

The address registers come as a pair: one supplies addresses for reads and the other for writes. The control register sets whether host address cycles reach both registers or only the one that a select bit picks. Address and control accesses ignore the halfword-select line. Data accesses use it to build 32-bit words from two 16-bit halves. A finished data cycle is passed downstream as a request with address, direction and write data, and the host is held with a wait signal until the downstream side acknowledges. Writing a one to the interrupt bit of the control register sends a single-cycle pulse to the CPU.

Top module: `host_port_decoder`

## Requirements
- R1: A host cycle starts on the clock where the internal strobe becomes active. The strobe is active when hostCsN is low and exactly one of hostStrb1N and hostStrb2N is low. With chip select high, or with both data strobes low, the block ignores the host entirely.
- R2: hostCtl selects the target: 2'b00 is the control register, 2'b10 the address registers, 2'b01 a data cycle with address auto-increment, 2'b11 a data cycle without it. Control and address cycles never raise dataReq.
- R3: Control register, 16 bits wide: bit 1 is the dual-address mode flag and bit 2 the address select (1 = write-address register, 0 = read-address register). Bit 0 and bits 15:3 always read as zero, and writes to bits 15:3 are discarded. hostHalfSel has no effect on control accesses.
- R4: A control write with bit 0 set drives cpuInt high for exactly one clock, in the cycle after the start clock edge.
- R5: Address cycles ignore hostHalfSel. The first address cycle after any other cycle type reaches bits 15:0 and the next reaches bits 31:16, alternating from there. A write changes an address register only on the upper halfword, which commits all 32 bits at once.
- R6: With dual-address mode clear, an address write updates both address registers, and an address read returns the read-address register.
- R7: With dual-address mode set, the address select bit picks the single register that address writes and reads reach.
- R8: Reads of the control or address registers never assert hostWait. The value appears on hostDataOut in the cycle after the start edge.
- R9: A data write with hostHalfSel low only stores the low halfword. With hostHalfSel high it raises dataReq with dataWrite=1, dataAddr equal to the write-address register and dataWdata equal to {current halfword, stored low halfword}. dataReq and hostWait stay high with the request fields stable until dataAck is sampled high.
- R10: A data read with hostHalfSel low raises dataReq with dataWrite=0 at the read-address register and holds hostWait until dataAck. hostDataOut then carries dataRdata[15:0]. A data read with hostHalfSel high makes no request and returns bits 31:16 of the last word fetched.
- R11: When a cycle with code 2'b01 is acknowledged, the address register it used (read or write) grows by 4. Code 2'b11 leaves it unchanged.
- R12: After reset, every register reads zero, dataReq, hostWait and cpuInt are low, and hostDataOut is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostStrb1N | input | 1 | First host data strobe, active low |
| hostStrb2N | input | 1 | Second host data strobe, active low |
| hostCtl | input | 2 | Cycle target code |
| hostRead | input | 1 | 1 = host read, 0 = host write |
| hostHalfSel | input | 1 | Halfword select for data cycles |
| hostDataIn | input | 16 | Host write data |
| hostDataOut | output | 16 | Host read data |
| hostWait | output | 1 | High while the host must hold its cycle |
| cpuInt | output | 1 | Single-cycle interrupt pulse to the CPU |
| dataReq | output | 1 | Downstream data request pending |
| dataWrite | output | 1 | Request direction, 1 = write |
| dataAddr | output | 32 | Request address |
| dataWdata | output | 32 | Request write word |
| dataAck | input | 1 | Downstream acknowledge of the pending request |
| dataRdata | input | 32 | Downstream read word, valid with dataAck |

## Verification
The hardest state to reach from the ports is a split between the two address registers combined with an address halfword phase that a different cycle type has interrupted. For example, a read pointer moved away from the write pointer by auto-increment, then read back one halfword at a time after a control access has reset the phase. The stimulus reaches this with a long run of fully random cycles (random code, direction, halfword select, strobe choice and acknowledge delay) against a bench model. Directed sequences are added for a lone lower-halfword address write, the both-strobes-low case and the interrupt pulse.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  parameter int HALF_W    = 16;
  parameter int ADDR_W    = 32;
  parameter int ADDR_STEP = 4;
  localparam int WORD_W   = 2 * HALF_W;

  typedef enum logic [1:0] {
    CMD_CTL      = 2'b00,
    CMD_DATA_INC = 2'b01,
    CMD_ADDR     = 2'b10,
    CMD_DATA     = 2'b11
  } hostCmdE;

  typedef enum logic [1:0] {
    OUT_CTL  = 2'd0,
    OUT_ADDR = 2'd1,
    OUT_DHI  = 2'd2
  } outSelE;

  typedef struct packed {
    logic   ctlWr;
    logic   addrLoWr;
    logic   addrHiWr;
    logic   dataLoWr;
    logic   issueWr;
    logic   issueRd;
    logic   ackWr;
    logic   ackRd;
    logic   autoInc;
    logic   outLoad;
    outSelE outSel;
    logic   addrHi;
  } hpcStrobesT;
endpackage

// File: rtl/hpc_ctrl.sv
module hpc_ctrl
  import hpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostCsN,
  input  logic       hostStrb1N,
  input  logic       hostStrb2N,
  input  logic [1:0] hostCtl,
  input  logic       hostRead,
  input  logic       hostHalfSel,
  input  logic       dataAck,
  output hpcStrobesT strobes,
  output logic       pending
);
  logic stbNow, stbPrev, cycStart;
  logic pendRead, pendAuto, addrPhase;
  hostCmdE cmd;

  assign stbNow   = ~hostCsN & (hostStrb1N ^ hostStrb2N);
  assign cycStart = stbNow & ~stbPrev & ~pending;
  assign cmd      = hostCmdE'(hostCtl);

  always_comb begin
    strobes = '0;
    strobes.outSel = OUT_CTL;
    if (cycStart) begin
      case (cmd)
        CMD_CTL: begin
          if (hostRead) begin
            strobes.outLoad = 1'b1;
            strobes.outSel  = OUT_CTL;
          end else begin
            strobes.ctlWr = 1'b1;
          end
        end
        CMD_ADDR: begin
          if (hostRead) begin
            strobes.outLoad = 1'b1;
            strobes.outSel  = OUT_ADDR;
            strobes.addrHi  = addrPhase;
          end else if (addrPhase) begin
            strobes.addrHiWr = 1'b1;
          end else begin
            strobes.addrLoWr = 1'b1;
          end
        end
        default: begin
          if (hostRead) begin
            if (hostHalfSel) begin
              strobes.outLoad = 1'b1;
              strobes.outSel  = OUT_DHI;
            end else begin
              strobes.issueRd = 1'b1;
            end
          end else if (hostHalfSel) begin
            strobes.issueWr = 1'b1;
          end else begin
            strobes.dataLoWr = 1'b1;
          end
        end
      endcase
    end
    if (pending && dataAck) begin
      strobes.ackWr   = ~pendRead;
      strobes.ackRd   = pendRead;
      strobes.autoInc = pendAuto;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbPrev   <= 1'b0;
      pending   <= 1'b0;
      pendRead  <= 1'b0;
      pendAuto  <= 1'b0;
      addrPhase <= 1'b0;
    end else begin
      stbPrev <= stbNow;
      if (cycStart) begin
        addrPhase <= (cmd == CMD_ADDR) ? ~addrPhase : 1'b0;
      end
      if (strobes.issueWr || strobes.issueRd) begin
        pending  <= 1'b1;
        pendRead <= strobes.issueRd;
        pendAuto <= (cmd == CMD_DATA_INC);
      end else if (pending && dataAck) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hpc_datapath.sv
module hpc_datapath
  import hpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hpcStrobesT        strobes,
  input  logic [HALF_W-1:0] hostDataIn,
  input  logic [WORD_W-1:0] dataRdata,
  output logic [HALF_W-1:0] hostDataOut,
  output logic              cpuInt,
  output logic              dataWrite,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [WORD_W-1:0] dataWdata
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ADDR_STEP);

  logic              dualMode, addrSel;
  logic [ADDR_W-1:0] rdAddr, wrAddr, selAddr;
  logic [HALF_W-1:0] addrLoHold, dataLoHold, ctlView;
  logic [WORD_W-1:0] rdHold;
  logic [ADDR_W-1:0] newAddr;
  logic              hitRd, hitWr;

  assign ctlView = {{(HALF_W-3){1'b0}}, addrSel, dualMode, 1'b0};
  assign selAddr = (dualMode && addrSel) ? wrAddr : rdAddr;
  assign newAddr = {hostDataIn, addrLoHold};
  assign hitRd   = strobes.addrHiWr && (!dualMode || !addrSel);
  assign hitWr   = strobes.addrHiWr && (!dualMode || addrSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dualMode   <= 1'b0;
      addrSel    <= 1'b0;
      cpuInt     <= 1'b0;
      addrLoHold <= '0;
      dataLoHold <= '0;
    end else begin
      cpuInt <= strobes.ctlWr & hostDataIn[0];
      if (strobes.ctlWr) begin
        dualMode <= hostDataIn[1];
        addrSel  <= hostDataIn[2];
      end
      if (strobes.addrLoWr) addrLoHold <= hostDataIn;
      if (strobes.dataLoWr) dataLoHold <= hostDataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr <= '0;
      wrAddr <= '0;
    end else begin
      if (hitRd) rdAddr <= newAddr;
      else if (strobes.ackRd && strobes.autoInc) rdAddr <= rdAddr + STEP;
      if (hitWr) wrAddr <= newAddr;
      else if (strobes.ackWr && strobes.autoInc) wrAddr <= wrAddr + STEP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataWrite <= 1'b0;
      dataAddr  <= '0;
      dataWdata <= '0;
    end else if (strobes.issueWr) begin
      dataWrite <= 1'b1;
      dataAddr  <= wrAddr;
      dataWdata <= {hostDataIn, dataLoHold};
    end else if (strobes.issueRd) begin
      dataWrite <= 1'b0;
      dataAddr  <= rdAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdHold      <= '0;
      hostDataOut <= '0;
    end else if (strobes.ackRd) begin
      rdHold      <= dataRdata;
      hostDataOut <= dataRdata[HALF_W-1:0];
    end else if (strobes.outLoad) begin
      case (strobes.outSel)
        OUT_CTL:  hostDataOut <= ctlView;
        OUT_ADDR: hostDataOut <= strobes.addrHi ? selAddr[ADDR_W-1:HALF_W]
                                                : selAddr[HALF_W-1:0];
        default:  hostDataOut <= rdHold[WORD_W-1:HALF_W];
      endcase
    end
  end
endmodule

// File: rtl/host_port_decoder.sv
module host_port_decoder
  import hpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostStrb1N,
  input  logic              hostStrb2N,
  input  logic [1:0]        hostCtl,
  input  logic              hostRead,
  input  logic              hostHalfSel,
  input  logic [HALF_W-1:0] hostDataIn,
  output logic [HALF_W-1:0] hostDataOut,
  output logic              hostWait,
  output logic              cpuInt,
  output logic              dataReq,
  output logic              dataWrite,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [WORD_W-1:0] dataWdata,
  input  logic              dataAck,
  input  logic [WORD_W-1:0] dataRdata
);
  hpcStrobesT strobes;
  logic       pending;

  hpc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostCsN(hostCsN), .hostStrb1N(hostStrb1N), .hostStrb2N(hostStrb2N),
    .hostCtl(hostCtl), .hostRead(hostRead), .hostHalfSel(hostHalfSel),
    .dataAck(dataAck), .strobes(strobes), .pending(pending)
  );

  hpc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hostDataIn(hostDataIn), .dataRdata(dataRdata),
    .hostDataOut(hostDataOut), .cpuInt(cpuInt),
    .dataWrite(dataWrite), .dataAddr(dataAddr), .dataWdata(dataWdata)
  );

  assign dataReq  = pending;
  assign hostWait = pending;
endmodule

// File: rtl/hpc_checker.sv
module hpc_checker
  import hpc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              hostCsN,
  input logic              hostStrb1N,
  input logic              hostStrb2N,
  input logic [1:0]        hostCtl,
  input logic              hostRead,
  input logic              hostWait,
  input logic              cpuInt,
  input logic              dataReq,
  input logic              dataWrite,
  input logic [ADDR_W-1:0] dataAddr,
  input logic [WORD_W-1:0] dataWdata,
  input logic              dataAck
);
  logic hostStb;
  assign hostStb = !hostCsN && (hostStrb1N != hostStrb2N);

  a_r8_reg_read_no_wait: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hostStb) && !hostWait && !hostCtl[0] && hostRead) |=> !hostWait);

  a_r2_reg_access_no_req: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hostStb) && !hostWait && !hostCtl[0]) |=> !dataReq);

  a_r4_int_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    cpuInt |=> !cpuInt);

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (dataReq && !dataAck) |=> (dataReq && $stable(dataAddr) && $stable(dataWrite)
                               && $stable(dataWdata)));

  a_r10_ack_ends_req: assert property (@(posedge clk) disable iff (!rstN)
    (dataReq && dataAck) |=> !dataReq);
endmodule

bind host_port_decoder hpc_checker u_chk (
  .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostStrb1N(hostStrb1N),
  .hostStrb2N(hostStrb2N), .hostCtl(hostCtl), .hostRead(hostRead),
  .hostWait(hostWait), .cpuInt(cpuInt), .dataReq(dataReq),
  .dataWrite(dataWrite), .dataAddr(dataAddr), .dataWdata(dataWdata),
  .dataAck(dataAck)
);

// File: tb/tb_host_port_decoder.sv
`timescale 1ns/1ps
module tb_host_port_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostCsN = 1'b1, hostStrb1N = 1'b1, hostStrb2N = 1'b1;
  logic [1:0]  hostCtl = 2'b00;
  logic        hostRead = 1'b0, hostHalfSel = 1'b0;
  logic [15:0] hostDataIn = '0;
  logic [15:0] hostDataOut;
  logic        hostWait, cpuInt, dataReq, dataWrite;
  logic [31:0] dataAddr, dataWdata;
  logic        dataAck = 1'b0;
  logic [31:0] dataRdata = '0;

  int testCount = 0;
  int failCount = 0;
  int ackDelay = 0;

  // bench model
  logic [31:0] mRd = '0, mWr = '0, mHold = '0;
  logic [15:0] mLo = '0, mDlo = '0;
  logic        mDual = 1'b0, mSel = 1'b0, mPhase = 1'b0;

  always #4 clk = ~clk;

  host_port_decoder dut (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostStrb1N(hostStrb1N),
    .hostStrb2N(hostStrb2N), .hostCtl(hostCtl), .hostRead(hostRead),
    .hostHalfSel(hostHalfSel), .hostDataIn(hostDataIn), .hostDataOut(hostDataOut),
    .hostWait(hostWait), .cpuInt(cpuInt), .dataReq(dataReq), .dataWrite(dataWrite),
    .dataAddr(dataAddr), .dataWdata(dataWdata), .dataAck(dataAck), .dataRdata(dataRdata)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h1234};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // downstream responder
  initial begin
    forever begin
      @(negedge clk);
      if (dataAck) begin
        dataAck = 1'b0;
        ackDelay = $urandom % 3;
      end else if (dataReq) begin
        if (ackDelay == 0) begin
          dataAck = 1'b1;
          dataRdata = memWord(dataAddr);
        end else begin
          ackDelay--;
        end
      end
    end
  end

  task automatic hostCycle(input logic [1:0] c, input logic rd, input logic hs,
                           input logic [15:0] din, output logic [15:0] outV,
                           output logic int1, output logic int2, output logic wait1,
                           output logic req1, output logic wr1,
                           output logic [31:0] addr1, output logic [31:0] wd1);
    @(negedge clk);
    hostCtl = c; hostRead = rd; hostHalfSel = hs; hostDataIn = din;
    hostCsN = 1'b0;
    if ($urandom % 2 == 0) begin hostStrb1N = 1'b0; hostStrb2N = 1'b1; end
    else begin hostStrb1N = 1'b1; hostStrb2N = 1'b0; end
    @(negedge clk);
    int1 = cpuInt; wait1 = hostWait; req1 = dataReq; wr1 = dataWrite;
    addr1 = dataAddr; wd1 = dataWdata;
    while (hostWait) @(negedge clk);
    outV = hostDataOut;
    @(negedge clk);
    int2 = cpuInt;
    hostCsN = 1'b1; hostStrb1N = 1'b1; hostStrb2N = 1'b1;
    @(negedge clk);
  endtask

  task automatic doOp(input logic [1:0] c, input logic rd, input logic hs,
                      input logic [15:0] din);
    logic [15:0] outV;
    logic        int1, int2, wait1, req1, wr1;
    logic [31:0] addr1, wd1, sel;
    hostCycle(c, rd, hs, din, outV, int1, int2, wait1, req1, wr1, addr1, wd1);
    case (c)
      2'b00: begin
        mPhase = 1'b0;
        check(!req1, "R2 ctl no request", {31'b0, req1}, 0);
        if (rd) begin
          check(outV == {13'b0, mSel, mDual, 1'b0}, "R3 ctl readback", outV,
                {16'b0, 13'b0, mSel, mDual, 1'b0});
          check(!wait1, "R8 ctl read no wait", {31'b0, wait1}, 0);
        end else begin
          check(int1 == din[0], "R4 interrupt pulse", {31'b0, int1}, {31'b0, din[0]});
          check(!int2, "R4 pulse one cycle", {31'b0, int2}, 0);
          mDual = din[1]; mSel = din[2];
        end
      end
      2'b10: begin
        check(!req1, "R2 addr no request", {31'b0, req1}, 0);
        if (rd) begin
          sel = (mDual && mSel) ? mWr : mRd;
          check(outV == (mPhase ? sel[31:16] : sel[15:0]), "R5 R6 R7 addr readback",
                {16'b0, outV}, {16'b0, mPhase ? sel[31:16] : sel[15:0]});
          check(!wait1, "R8 addr read no wait", {31'b0, wait1}, 0);
        end else if (!mPhase) begin
          mLo = din;
        end else begin
          if (!mDual || !mSel) mRd = {din, mLo};
          if (!mDual || mSel) mWr = {din, mLo};
        end
        mPhase = ~mPhase;
      end
      default: begin
        mPhase = 1'b0;
        if (!rd && !hs) begin
          check(!req1, "R9 low half no request", {31'b0, req1}, 0);
          mDlo = din;
        end else if (!rd) begin
          check(req1 && wr1, "R9 write request", {30'b0, req1, wr1}, 3);
          check(addr1 == mWr, "R9 R11 write address", addr1, mWr);
          check(wd1 == {din, mDlo}, "R9 write word", wd1, {din, mDlo});
          if (c == 2'b01) mWr = mWr + 4;
        end else if (!hs) begin
          check(req1 && !wr1, "R10 read request", {30'b0, req1, wr1}, 2);
          check(addr1 == mRd, "R10 R11 read address", addr1, mRd);
          mHold = memWord(mRd);
          check(outV == mHold[15:0], "R10 low half data", {16'b0, outV}, {16'b0, mHold[15:0]});
          if (c == 2'b01) mRd = mRd + 4;
        end else begin
          check(!req1, "R10 high half no request", {31'b0, req1}, 0);
          check(outV == mHold[31:16], "R10 high half data", {16'b0, outV}, {16'b0, mHold[31:16]});
        end
      end
    endcase
  endtask

  initial begin
    #(8 * 200000);
    failCount++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic seenInt;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(!hostWait && !dataReq && !cpuInt, "R12 reset outputs",
          {29'b0, hostWait, dataReq, cpuInt}, 0);
    check(hostDataOut == 16'h0, "R12 reset data out", {16'b0, hostDataOut}, 0);
    doOp(2'b00, 1'b1, 1'b0, 16'h0);
    doOp(2'b10, 1'b1, 1'b0, 16'h0);
    doOp(2'b10, 1'b1, 1'b1, 16'h0);

    // R3 reserved bits and halfSel ignored; R4 pulse
    doOp(2'b00, 1'b0, 1'b1, 16'hFFF9);
    doOp(2'b00, 1'b1, 1'b1, 16'h0);
    doOp(2'b00, 1'b0, 1'b0, 16'h0000);

    // R6 shared address write, then R5 lone lower halfword is not committed
    doOp(2'b10, 1'b0, 1'b1, 16'h5678);
    doOp(2'b10, 1'b0, 1'b0, 16'h1234);
    doOp(2'b10, 1'b0, 1'b0, 16'hBEEF);
    doOp(2'b00, 1'b1, 1'b0, 16'h0);
    doOp(2'b10, 1'b1, 1'b1, 16'h0);
    doOp(2'b10, 1'b1, 1'b0, 16'h0);

    // R7 dual mode, select write register, then read register
    doOp(2'b00, 1'b0, 1'b0, 16'h0006);
    doOp(2'b10, 1'b0, 1'b0, 16'h0100);
    doOp(2'b10, 1'b0, 1'b0, 16'hA000);
    doOp(2'b10, 1'b1, 1'b0, 16'h0);
    doOp(2'b10, 1'b1, 1'b0, 16'h0);
    doOp(2'b00, 1'b0, 1'b0, 16'h0002);
    doOp(2'b10, 1'b1, 1'b0, 16'h0);
    doOp(2'b10, 1'b1, 1'b0, 16'h0);

    // R9 R10 R11 data cycles with and without increment
    doOp(2'b01, 1'b0, 1'b0, 16'h1111);
    doOp(2'b01, 1'b0, 1'b1, 16'h2222);
    doOp(2'b11, 1'b0, 1'b0, 16'h3333);
    doOp(2'b11, 1'b0, 1'b1, 16'h4444);
    doOp(2'b01, 1'b1, 1'b0, 16'h0);
    doOp(2'b01, 1'b1, 1'b1, 16'h0);
    doOp(2'b11, 1'b1, 1'b0, 16'h0);
    doOp(2'b11, 1'b1, 1'b1, 16'h0);

    // R1 both strobes low, and chip select high: no cycle
    @(negedge clk);
    seenInt = 1'b0;
    hostCtl = 2'b00; hostRead = 1'b0; hostDataIn = 16'h0007;
    hostCsN = 1'b0; hostStrb1N = 1'b0; hostStrb2N = 1'b0;
    repeat (3) begin @(negedge clk); seenInt |= cpuInt; end
    hostCsN = 1'b1; hostStrb1N = 1'b0; hostStrb2N = 1'b1;
    repeat (3) begin @(negedge clk); seenInt |= cpuInt; end
    hostStrb1N = 1'b1;
    @(negedge clk);
    check(!seenInt, "R1 no cycle without valid strobe", {31'b0, seenInt}, 0);
    doOp(2'b00, 1'b1, 1'b0, 16'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      doOp(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2), 16'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule